// File: doc/BRIEF.md
# Counter Test Pattern Source

This block replaces the channelized or raw sample stream with a known, fully predictable pattern. A downstream consumer, or software reading memory after a capture, can then confirm that no sample was lost or duplicated, that frame boundaries sit where they should, and that words landed in memory in the correct order. Every transferred word holds four complex samples. The real half of each sample gives its position inside a 512-sample frame. The imaginary half gives the number of the frame.

The output is a valid/ready stream. `pat_valid` is high whenever the source is enabled and not in reset, and it does not depend on `pat_ready`. A word is taken on a rising clock edge where both `pat_valid` and `pat_ready` are high. While the consumer holds `pat_ready` low, the word on `pat_data` stays the same until it is taken, so back-pressure never loses or skips a sample. Dropping `src_en` freezes the pattern exactly where it stands. The synchronous reset `src_srst` restarts the pattern at sample 0 of frame 0.

Top module: `ctp_counter_source`

## Requirements
- R1: Lane k (k = 0..3) of a word carries in its real part the sample index base+k, where base is 0 after reset.
- R2: The imaginary part of every lane of a word equals the current frame index, which is 0 after reset.
- R3: Lane k occupies `pat_data[32k+31:32k]`. Within a lane the real part is bits [15:0] and the imaginary part is bits [31:16], both unsigned 16-bit.
- R4: Each accepted word (`pat_valid` and `pat_ready` both high at a rising edge) advances base by 4, so one 512-sample frame spans 128 words.
- R5: The word after the one carrying samples 508..511 carries samples 0..3, and its frame index is one higher.
- R6: The frame index is 16 bits wide and wraps from 65535 to 0.
- R7: While `pat_valid` is high and `pat_ready` is low, `pat_data` holds its value on the next cycle.
- R8: While `src_en` is low, `pat_valid` is low and the counters hold. After re-enabling, the same word that was pending is presented again.
- R9: A clock edge with `src_srst` high clears both counters, and `pat_valid` is low while `src_srst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| src_srst | input | 1 | Synchronous reset, active high |
| src_en | input | 1 | Enables the pattern stream |
| pat_ready | input | 1 | Consumer can take the current word |
| pat_valid | output | 1 | Current word is valid |
| pat_data | output | 128 | Four packed complex samples |

## Verification
The hardest condition to reach is the wrap of the frame index from 65535 to 0. At the default frame length it needs more than eight million words. The bench therefore runs a second instance with the frame length set to 8 samples, which is two words per frame. It streams that instance with ready held high for 131072 words, which reaches the last word of frame 65535 and then the first word of frame 0. The default instance covers the 512-sample boundary, back-pressure, disable and reset in the middle of a frame.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int unsigned DEF_LANES     = 4;
  localparam int unsigned DEF_SAMPLE_W  = 16;
  localparam int unsigned DEF_FRAME_LEN = 512;

  // Width of a counter that must hold values 0..n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ctp_index_cnt.sv
module ctp_index_cnt #(
  parameter int unsigned LANES     = ctp_pkg::DEF_LANES,
  parameter int unsigned FRAME_LEN = ctp_pkg::DEF_FRAME_LEN,
  localparam int unsigned IDX_W    = ctp_pkg::cnt_width(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             step,
  output logic [IDX_W-1:0] base,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(FRAME_LEN - LANES);
  localparam logic [IDX_W-1:0] STRIDE    = IDX_W'(LANES);

  assign last = (base == LAST_BASE);

  always_ff @(posedge clk) begin
    if (srst)      base <= '0;
    else if (step) base <= last ? '0 : base + STRIDE;
  end

  // R4: base stays a lane-aligned index inside the frame
  p_base_align_r4: assert property (@(posedge clk) disable iff (srst)
    (32'(base) % LANES == 0) && (32'(base) < FRAME_LEN));

  // R9: a reset edge clears the sample index
  p_reset_clear_r9: assert property (@(posedge clk)
    srst |=> (base == '0));
endmodule

// File: rtl/ctp_frame_cnt.sv
module ctp_frame_cnt #(
  parameter int unsigned FRAME_W = ctp_pkg::DEF_SAMPLE_W
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               bump,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (srst)      frame <= '0;
    else if (bump) frame <= frame + FRAME_W'(1);
  end

  // R5 / R6: frame moves by exactly one, modulo 2^FRAME_W, on a frame end
  p_frame_step_r5: assert property (@(posedge clk) disable iff (srst)
    bump |=> (frame == FRAME_W'($past(frame) + FRAME_W'(1))));

  // R5: otherwise the frame index is stable
  p_frame_hold_r5: assert property (@(posedge clk) disable iff (srst)
    !bump |=> $stable(frame));
endmodule

// File: rtl/ctp_lane_pack.sv
module ctp_lane_pack #(
  parameter int unsigned LANES    = ctp_pkg::DEF_LANES,
  parameter int unsigned SAMPLE_W = ctp_pkg::DEF_SAMPLE_W,
  parameter int unsigned IDX_W    = 9,
  localparam int unsigned LANE_W  = 2 * SAMPLE_W,
  localparam int unsigned WORD_W  = LANES * LANE_W
) (
  input  logic [IDX_W-1:0]    base,
  input  logic [SAMPLE_W-1:0] frame,
  output logic [WORD_W-1:0]   word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SAMPLE_W-1:0] re;
    assign re = SAMPLE_W'(base) + SAMPLE_W'(k);
    assign word[k*LANE_W +: SAMPLE_W]            = re;
    assign word[k*LANE_W + SAMPLE_W +: SAMPLE_W] = frame;
  end
endmodule

// File: rtl/ctp_counter_source.sv
module ctp_counter_source #(
  parameter int unsigned LANES     = ctp_pkg::DEF_LANES,
  parameter int unsigned SAMPLE_W  = ctp_pkg::DEF_SAMPLE_W,
  parameter int unsigned FRAME_LEN = ctp_pkg::DEF_FRAME_LEN,
  localparam int unsigned IDX_W    = ctp_pkg::cnt_width(FRAME_LEN),
  localparam int unsigned WORD_W   = LANES * 2 * SAMPLE_W
) (
  input  logic              clk,
  input  logic              src_srst,
  input  logic              src_en,
  input  logic              pat_ready,
  output logic              pat_valid,
  output logic [WORD_W-1:0] pat_data
);
  logic [IDX_W-1:0]    base;
  logic                last;
  logic [SAMPLE_W-1:0] frame;
  logic                take;

  assign pat_valid = src_en && !src_srst;
  assign take      = pat_valid && pat_ready;

  ctp_index_cnt #(.LANES(LANES), .FRAME_LEN(FRAME_LEN)) u_idx (
    .clk(clk), .srst(src_srst), .step(take), .base(base), .last(last)
  );

  ctp_frame_cnt #(.FRAME_W(SAMPLE_W)) u_frm (
    .clk(clk), .srst(src_srst), .bump(take && last), .frame(frame)
  );

  ctp_lane_pack #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_pack (
    .base(base), .frame(frame), .word(pat_data)
  );

  // R7: a stalled word is held for the consumer
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (src_srst)
    (pat_valid && !pat_ready) |=> $stable(pat_data));

  // R8: a disabled source does not move the pattern
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (src_srst)
    !src_en |=> $stable(pat_data));
endmodule

// File: tb/test_ctp_counter_source.sv
module test_ctp_counter_source;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         srst, en, rdy, vld;
  logic [127:0] data;
  logic         s_srst, s_en, s_rdy, s_vld;
  logic [127:0] s_data;

  int checks = 0;
  int fails  = 0;
  int exp_base  = 0;
  int exp_frame = 0;

  ctp_counter_source i_ctp_counter_source (
    .clk(clk), .src_srst(srst), .src_en(en), .pat_ready(rdy),
    .pat_valid(vld), .pat_data(data)
  );

  ctp_counter_source #(.FRAME_LEN(8)) i_ctp_counter_source_short (
    .clk(clk), .src_srst(s_srst), .src_en(s_en), .pat_ready(s_rdy),
    .pat_valid(s_vld), .pat_data(s_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1 R2 R3: every lane decoded from its documented bit position
  task automatic chk_word(input string req, input logic [127:0] w,
                          input int base, input int frame);
    for (int k = 0; k < 4; k++) begin
      chk({req, " real"}, w[32*k +: 16], (base + k) & 16'hffff);
      chk({req, " imag"}, w[32*k + 16 +: 16], frame & 16'hffff);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (vld && rdy) begin
      if (exp_base == 508) begin exp_base = 0; exp_frame = (exp_frame + 1) % 65536; end
      else exp_base += 4;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    srst = 1; en = 1; rdy = 1;
    cyc(); cyc();
    exp_base = 0; exp_frame = 0;
    chk("R9 valid low in reset", vld, 0);
    srst = 0; en = 0;
    cyc();
    chk("R8 valid low when disabled", vld, 0);
    en = 1;
    #1;
    chk("R1 valid after enable", vld, 1);
    chk_word("R1 R2 R3 first word", data, 0, 0);
    chk("R3 raw lane1 real", data[47:32], 1);
    chk("R3 raw lane3 real", data[111:96], 3);
  endtask

  task automatic t_stream();
    rdy = 1;
    while (!(exp_base == 508 && exp_frame == 0)) begin
      cyc();
      chk_word("R4 stream", data, exp_base, exp_frame);
    end
    chk_word("R5 last word of frame", data, 508, 0);
    cyc();
    chk_word("R5 first word of next frame", data, 0, 1);
  endtask

  task automatic t_backpressure();
    logic [127:0] held;
    held = data;
    rdy = 0;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R7 valid during stall", vld, 1);
      chk("R7 held real", data[15:0], held[15:0]);
      chk("R7 held word", (data == held), 1);
    end
    rdy = 1;
    cyc();
    chk_word("R7 resume", data, exp_base, exp_frame);
    chk("R4 resume advanced by 4", data[15:0], held[15:0] + 4);
  endtask

  task automatic t_disable();
    logic [127:0] held;
    held = data;
    en = 0;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk("R8 valid low", vld, 0);
    end
    en = 1;
    #1;
    chk("R8 same word after enable", (data == held), 1);
    cyc();
    chk_word("R8 continues", data, exp_base, exp_frame);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 10; i++) cyc();
    chk("R9 not at start before reset", (data[15:0] != 0) || (data[31:16] != 0), 1);
    srst = 1;
    cyc();
    chk("R9 valid low in reset", vld, 0);
    exp_base = 0; exp_frame = 0;
    srst = 0;
    #1;
    chk_word("R9 cleared", data, 0, 0);
  endtask

  task automatic t_wrap();
    s_srst = 1; s_en = 1; s_rdy = 1;
    @(posedge clk); @(negedge clk);
    s_srst = 0;
    // 2 words per frame: 131071 words reach the last word of frame 65535
    for (int i = 0; i < 131071; i++) @(posedge clk);
    @(negedge clk);
    chk("R6 frame at 65535", s_data[31:16], 16'hffff);
    chk("R6 last real", s_data[15:0], 4);
    @(posedge clk); @(negedge clk);
    chk("R6 frame wrapped to 0", s_data[31:16], 0);
    chk("R6 real restarts", s_data[15:0], 0);
    chk("R6 lane3 imag wrapped", s_data[127:112], 0);
  endtask

  initial begin
    srst = 1; en = 0; rdy = 0;
    s_srst = 1; s_en = 0; s_rdy = 0;
    @(negedge clk);
    t_reset();
    t_stream();
    t_backpressure();
    t_disable();
    t_reset_mid();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule